// File: doc/BRIEF.md
# Mini UART Register Front End

This block gives software a word-addressed window of 256 bytes onto a minimal UART. Behind the window sit a circular receive queue and an interrupt enable register. Identification, line status and extended status words are built from the live queue state. A single level-sensitive interrupt line leaves the block.

Received bytes enter through a byte-wide valid/ready port. A byte is taken only while the queue has room. Bytes that software writes to the data offset leave at once as a one-cycle strobe on a byte-wide output. The transmit side is treated as always idle and empty, so the status words report it that way.

Bus accesses are one cycle long. Read data is registered and appears on the cycle after the access. Side effects of the access (popping a byte, flushing the queue, storing enables) take effect at the same clock edge.

Top module: `mu_regfront`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty and both enables are clear. The read data bus, `irq` and `tx_valid` are 0, and the receive side is ready.
- R2: A write to offset 0x44 stores only bits 1 (receive) and 0 (transmit) of the written value. A read of 0x44 returns 0xC0 ORed with the stored pair.
- R3: `rx_ready` is high exactly when fewer than 8 bytes are queued, and no flush write is in progress. An accepted byte is stored behind the ones already queued. Bytes leave in arrival order, and the storage slots wrap after 8.
- R4: A read of offset 0x40 returns the oldest queued byte and removes it. On an empty queue, the same read returns whatever the slot at the read position last held, and it removes nothing.
- R5: `irq` is high when the transmit enable is set, or when the receive enable is set and the queue is not empty. A read of offset 0x00 returns 1 while `irq` is high and 0 otherwise.
- R6: A read of offset 0x48 returns 0xC0 ORed with 0x4 if the queue holds data, or with 0x2 if it is empty. Bit 0 is also set when no interrupt is pending.
- R7: A write to offset 0x48 with bit 1 set empties the queue. A write to 0x48 with bit 1 clear leaves the queue unchanged.
- R8: A read of offset 0x54 returns 0x60, with bit 0 set when the queue is not empty. A read of offset 0x64 returns 0x30E, with bit 0 set when the queue is not empty and the queued byte count in bits 19:16.
- R9: Offset 0x04 reads 1 and offset 0x60 reads 0x3. Offsets 0x4C, 0x50, 0x58, 0x5C and 0x68 read 0, as does any other unlisted offset. A write to any of these offsets changes no state.
- R10: A write to offset 0x40 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits 7:0 of the written value.
- R11: Read data for an access appears on `bus_rdata` in the cycle after the access, and reflects the state before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte will be taken this cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt request |

## Verification
Every bus result and every state change is due one clock edge after the access that causes it. This covers read data, the `tx_valid` strobe, a new queue count, and the interrupt level that follows from it. `rx_ready`, by contrast, is combinational and must be valid in the same cycle as the offered byte.

The bench drives each operation on a falling edge and compares `rx_ready` before the next rising edge. It compares read data, `tx_valid`/`tx_data` and `irq` on the following falling edge. The reference model is advanced only after those comparisons, so every expected read value comes from the state before the access.

// File: rtl/mu_pkg.sv
// Package: shared offsets, register select type and the address decoder
// for the mini UART register front end. Assumes word-aligned offsets.
package mu_pkg;

    localparam logic [5:0] W_PEND  = 6'h00;  // 0x00
    localparam logic [5:0] W_ENA   = 6'h01;  // 0x04
    localparam logic [5:0] W_DATA  = 6'h10;  // 0x40
    localparam logic [5:0] W_IEN   = 6'h11;  // 0x44
    localparam logic [5:0] W_IID   = 6'h12;  // 0x48
    localparam logic [5:0] W_LSTAT = 6'h15;  // 0x54
    localparam logic [5:0] W_CTRL  = 6'h18;  // 0x60
    localparam logic [5:0] W_XSTAT = 6'h19;  // 0x64

    localparam logic [7:0] IEN_RD_OR   = 8'hC0;
    localparam logic [7:0] LSTAT_BASE  = 8'h60;
    localparam logic [31:0] XSTAT_BASE = 32'h0000_030E;
    localparam logic [31:0] CTRL_VAL   = 32'h0000_0003;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENA,
        SEL_DATA,
        SEL_IEN,
        SEL_IID,
        SEL_LSTAT,
        SEL_CTRL,
        SEL_XSTAT
    } reg_sel_e;

    // Map a word index to the register it selects; unlisted words select nothing.
    function automatic reg_sel_e decode_word(input logic [5:0] w);
        case (w)
            W_PEND:  return SEL_PEND;
            W_ENA:   return SEL_ENA;
            W_DATA:  return SEL_DATA;
            W_IEN:   return SEL_IEN;
            W_IID:   return SEL_IID;
            W_LSTAT: return SEL_LSTAT;
            W_CTRL:  return SEL_CTRL;
            W_XSTAT: return SEL_XSTAT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mu_rx_fifo.sv
// Circular receive queue. The write slot is the read position plus the
// fill count, modulo DEPTH. A pop on an empty queue is ignored. A flush
// zeroes the count and leaves the read position where it is. Assumes the
// caller never asserts push while the queue is full or flushing.
module mu_rx_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              flush,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  fill,
    output logic              has_room
);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  rd_pos;
    logic [CNT_W-1:0]  cnt;
    logic [PTR_W-1:0]  wr_slot;
    logic              pop_ok;

    // Write slot: read position plus count, folded back into range.
    always_comb begin
        logic [CNT_W:0] sum;
        sum = (CNT_W + 1)'(rd_pos) + (CNT_W + 1)'(cnt);
        if (sum >= (CNT_W + 1)'(DEPTH))
            sum = sum - (CNT_W + 1)'(DEPTH);
        wr_slot = sum[PTR_W-1:0];
    end

    assign pop_ok    = pop_req && (cnt != '0);
    assign head_data = slots[rd_pos];
    assign fill      = cnt;
    assign has_room  = (cnt < CNT_W'(DEPTH));

    // One storage register per slot, loaded when the write slot hits it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (push && (wr_slot == PTR_W'(g)))
                slots[g] <= push_data;
        end
    end

    // Read position advances with wraparound on an effective pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_pos <= '0;
        else if (pop_ok)
            rd_pos <= (rd_pos == PTR_W'(DEPTH - 1)) ? '0 : rd_pos + 1'b1;
    end

    // Fill count: flush wins, otherwise add pushes and subtract pops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (flush)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop_ok);
    end

endmodule

// File: rtl/mu_irq_ctrl.sv
// Interrupt enable storage and pending logic. The pending vector is a
// function of the stored enables and the queue state, so it is current
// after every access and every received byte. The module also builds the
// identification byte, which gives the receive cause priority.
module mu_irq_ctrl #(
    localparam int EN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ien_wr,
    input  logic [EN_W-1:0] ien_wdata,
    input  logic            rx_nonempty,
    output logic [EN_W-1:0] ien_q,
    output logic [EN_W-1:0] pend,
    output logic            irq,
    output logic [7:0]      iid_byte
);

    localparam int TX_BIT = 0;
    localparam int RX_BIT = 1;

    // Enable register keeps only the two cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (ien_wr)
            ien_q <= ien_wdata;
    end

    // Pending causes: transmit is always ready, receive needs data.
    always_comb begin
        pend         = '0;
        pend[TX_BIT] = ien_q[TX_BIT];
        pend[RX_BIT] = ien_q[RX_BIT] && rx_nonempty;
    end

    assign irq = |pend;

    // Identification byte: receive cause first, bit 0 means nothing pending.
    always_comb begin
        iid_byte    = 8'hC0;
        iid_byte[2] = rx_nonempty;
        iid_byte[1] = !rx_nonempty;
        iid_byte[0] = !irq;
    end

endmodule

// File: rtl/mu_rd_mux.sv
// Read data composer and output register. Selects the word for the
// addressed register from the live state and loads it on a read access.
// The output holds between reads. Assumes the state inputs are the values
// before the access edge.
module mu_rd_mux
    import mu_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int EN_W   = 2,
    localparam int FILL_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] head_data,
    input  logic [EN_W-1:0]   ien_q,
    input  logic              irq,
    input  logic [7:0]        iid_byte,
    input  logic [CNT_W-1:0]  fill,
    output logic [BUS_W-1:0]  rdata
);

    logic [BUS_W-1:0] word;
    logic             nonempty;

    assign nonempty = (fill != '0);

    // Build the word for the selected register.
    always_comb begin
        word = '0;
        case (sel)
            SEL_PEND:  word[0] = irq;
            SEL_ENA:   word[0] = 1'b1;
            SEL_DATA:  word[DATA_W-1:0] = head_data;
            SEL_IEN:   word[7:0] = IEN_RD_OR | 8'(ien_q);
            SEL_IID:   word[7:0] = iid_byte;
            SEL_LSTAT: word[7:0] = LSTAT_BASE | 8'(nonempty);
            SEL_CTRL:  word = BUS_W'(CTRL_VAL);
            SEL_XSTAT: begin
                word = BUS_W'(XSTAT_BASE);
                word[0] = nonempty;
                word[FILL_LSB +: CNT_W] = fill;
            end
            default:   word = '0;
        endcase
    end

    // Capture the word on a read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= word;
    end

endmodule

// File: rtl/mu_regfront.sv
// Mini UART register front end, top level. Decodes one-cycle word
// accesses, steers side effects into the receive queue and the interrupt
// logic, and drives the transmit strobe. Assumes at most one bus access
// per cycle and a sender that honours rx_ready.
module mu_regfront
    import mu_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int EN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq
);

    reg_sel_e          sel;
    logic              wr_acc, rd_acc;
    logic              flush_now, pop_now, push_now;
    logic              has_room;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  fill_cnt;
    logic [EN_W-1:0]   ien_q, pend;
    logic [7:0]        iid_byte;

    // Access decode: word index from the upper offset bits.
    assign sel       = decode_word(bus_addr[7:2]);
    assign wr_acc    = bus_en && bus_we;
    assign rd_acc    = bus_en && !bus_we;
    assign flush_now = wr_acc && (sel == SEL_IID) && bus_wdata[1];
    assign pop_now   = rd_acc && (sel == SEL_DATA);
    assign rx_ready  = has_room && !flush_now;
    assign push_now  = rx_valid && rx_ready;

    mu_rx_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_now),
        .push_data (rx_data),
        .pop_req   (pop_now),
        .flush     (flush_now),
        .head_data (head_data),
        .fill      (fill_cnt),
        .has_room  (has_room)
    );

    mu_irq_ctrl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ien_wr      (wr_acc && (sel == SEL_IEN)),
        .ien_wdata   (bus_wdata[EN_W-1:0]),
        .rx_nonempty (fill_cnt != '0),
        .ien_q       (ien_q),
        .pend        (pend),
        .irq         (irq),
        .iid_byte    (iid_byte)
    );

    mu_rd_mux #(
        .BUS_W  (BUS_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .EN_W   (EN_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_acc),
        .sel       (sel),
        .head_data (head_data),
        .ien_q     (ien_q),
        .irq       (irq),
        .iid_byte  (iid_byte),
        .fill      (fill_cnt),
        .rdata     (bus_rdata)
    );

    // Transmit strobe: one cycle per data-register write, sent at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= wr_acc && (sel == SEL_DATA);
            if (wr_acc && (sel == SEL_DATA))
                tx_data <= bus_wdata[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/mu_regfront_chk.sv
// Checker for mu_regfront: port-level timing rules and queue count bounds.
// Bound to every instance of the top module.
module mu_regfront_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             irq,
    input logic [CNT_W-1:0] fill
);

    logic data_wr, data_rd, flush_wr;
    assign data_wr  = bus_en && bus_we && (bus_addr[7:2] == 6'h10);
    assign data_rd  = bus_en && !bus_we && (bus_addr[7:2] == 6'h10);
    assign flush_wr = bus_en && bus_we && (bus_addr[7:2] == 6'h12) && bus_wdata[1];

    // R1: reset leaves an empty queue, no interrupt and no strobe.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fill == '0 && !irq && !tx_valid));

    // R3: count never exceeds the depth.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R3: a full queue refuses input.
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH)) |-> !rx_ready);

    // R4: a data read on an empty queue with no arrival leaves it empty.
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fill == '0 && !(rx_valid && rx_ready)) |=> fill == '0);

    // R7: a flush write empties the queue at the next edge.
    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> fill == '0);

    // R10: a data write is followed by a strobe carrying the low byte.
    assert_tx_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    // R10: no strobe without a data write in the previous cycle.
    assert_tx_only_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !tx_valid);

endmodule

bind mu_regfront mu_regfront_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .fill      (fill_cnt)
);

// File: tb/test_mu_regfront.sv
// Bench for mu_regfront: directed corner cases, then seeded random traffic
// checked against a queue model held in the bench.
module test_mu_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_run = 0, n_fail = 0;

    // Model state
    logic [7:0] m_mem [8];
    int         m_head = 0, m_cnt = 0;
    logic [1:0] m_ien = 2'b00;

    always #4 clk = ~clk;  // 125 MHz

    mu_regfront i_mu_regfront (
        .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .rx_valid, .rx_data, .rx_ready, .tx_valid, .tx_data, .irq
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic m_irq();
        return m_ien[0] || (m_ien[1] && m_cnt != 0);
    endfunction

    // Expected read word for an offset, from the state before the access.
    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v;
        v = 32'h0;
        case (a[7:2])
            6'h00: v = {31'h0, m_irq()};
            6'h01: v = 32'h1;
            6'h10: v = {24'h0, m_mem[m_head]};
            6'h11: v = {24'h0, 8'hC0 | {6'h0, m_ien}};
            6'h12: v = {24'h0, 8'hC0 | ((m_cnt != 0) ? 8'h4 : 8'h2) | (m_irq() ? 8'h0 : 8'h1)};
            6'h15: v = {24'h0, 8'h60 | ((m_cnt != 0) ? 8'h1 : 8'h0)};
            6'h18: v = 32'h3;
            6'h19: v = 32'h30E | ((m_cnt != 0) ? 32'h1 : 32'h0) | (32'(m_cnt) << 16);
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a[7:2])
            6'h00: return "R5";
            6'h10: return "R4";
            6'h11: return "R2";
            6'h12: return "R6";
            6'h15, 6'h19: return "R8";
            default: return "R9";
        endcase
    endfunction

    // One bus cycle with an optional received byte; checks all results.
    task automatic cycle(input logic en, input logic we, input logic [7:0] a,
                         input logic [31:0] wd, input logic rv, input logic [7:0] rd);
        logic        flush, exp_rdy, acc, pop;
        logic [31:0] exp_rd;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_data = rd;
        flush   = en && we && a[7:2] == 6'h12 && wd[1];
        exp_rdy = (m_cnt < 8) && !flush;
        exp_rd  = exp_read(a);
        #1;
        check("R3 rx_ready", {31'h0, rx_ready}, {31'h0, exp_rdy});
        acc = rv && exp_rdy;
        pop = en && !we && a[7:2] == 6'h10 && m_cnt != 0;
        @(posedge clk);
        @(negedge clk);
        if (en && !we) check({req_of(a), " R11 read"}, bus_rdata, exp_rd);
        check("R10 tx_valid", {31'h0, tx_valid}, {31'h0, en && we && a[7:2] == 6'h10});
        if (en && we && a[7:2] == 6'h10) check("R10 tx_data", {24'h0, tx_data}, {24'h0, wd[7:0]});
        // Advance model
        if (acc) m_mem[(m_head + m_cnt) % 8] = rd;
        if (pop) m_head = (m_head + 1) % 8;
        m_cnt = m_cnt + (acc ? 1 : 0) - (pop ? 1 : 0);
        if (flush) m_cnt = 0;
        if (en && we && a[7:2] == 6'h11) m_ien = wd[1:0];
        check("R5 irq", {31'h0, irq}, {31'h0, m_irq()});
        bus_en = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        cycle(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h0);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cycle(1'b1, 1'b1, a, d, 1'b0, 8'h0);
    endtask
    task automatic push(input logic [7:0] d);
        cycle(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, d);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        for (int i = 0; i < 8; i++) m_mem[i] = 8'h0;
        seed = $urandom(32'h1F2E);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
        rd(8'h64); rd(8'h48); rd(8'h40);           // R4 empty read returns stale zero
        // R2 enables keep two bits
        wr(8'h44, 32'hFFFF_FFFE); rd(8'h44);
        push(8'hA1); rd(8'h00); rd(8'h48);         // R5/R6 receive pending
        wr(8'h44, 32'h1); rd(8'h48);
        wr(8'h44, 32'h0); rd(8'h00);
        // R3 fill to full, one refused
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
        rd(8'h64); rd(8'h54);
        for (int i = 0; i < 8; i++) rd(8'h40);     // R3 order, R4 pop with wrap
        rd(8'h40); rd(8'h40);                      // R4 stale, no change
        rd(8'h64);
        // R7 flush and non-flush writes
        push(8'h55); push(8'h66);
        wr(8'h48, 32'h4); rd(8'h64);
        cycle(1'b1, 1'b1, 8'h48, 32'h2, 1'b1, 8'h77);  // R7 ready low while flushing
        rd(8'h64); rd(8'h40);
        // R9 dead offsets
        push(8'h99); wr(8'h44, 32'h2);
        wr(8'h4C, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF); wr(8'h5C, 32'hFFFF_FFFF);
        wr(8'h68, 32'hFFFF_FFFF); wr(8'h04, 32'h0); wr(8'h60, 32'h0); wr(8'hF0, 32'hFFFF_FFFF);
        rd(8'h4C); rd(8'h50); rd(8'h58); rd(8'h5C); rd(8'h68); rd(8'hF0);
        rd(8'h04); rd(8'h60); rd(8'h44); rd(8'h64);
        // R10 back-to-back strobes then quiet
        wr(8'h40, 32'h1234_56AB); wr(8'h40, 32'h0000_00CD); rd(8'h54);
        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            int unsigned r, op;
            logic [7:0] a;
            r  = $urandom;
            op = r % 10;
            case (r[15:12])
                4'd0: a = 8'h00; 4'd1: a = 8'h04; 4'd2: a = 8'h44; 4'd3: a = 8'h48;
                4'd4: a = 8'h54; 4'd5: a = 8'h60; 4'd6: a = 8'h64; 4'd7: a = 8'h4C;
                default: a = 8'h40;
            endcase
            if (op < 4)      cycle(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, r[27:20]);
            else if (op < 7) cycle(1'b1, 1'b0, a, 32'h0, r[8], r[27:20]);
            else if (op < 8) cycle(1'b1, 1'b1, 8'h44, {30'h0, r[17:16]}, r[8], r[27:20]);
            else if (op < 9) cycle(1'b1, 1'b1, (r[4] ? 8'h48 : 8'h40), {28'h0, r[23:20]}, r[8], r[27:20]);
            else             cycle(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 8'h0);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule